// File: doc/BRIEF.md
# I2C Bus Master with 7-bit and 10-bit Slave Addressing

This block is the byte engine of an I2C bus master. A host issues a start command together with a slave address, an address-width choice and a transfer direction. The block then produces the whole address phase on the bus by itself. For a 10-bit read this means the two-byte address, a repeated START and the read-direction prefix byte, all without host help. During writes it takes data bytes from a one-entry transmit holding register. It raises a transmit interrupt as soon as the first bit of each data byte has left the shift register, so the host can refill the register while that byte is still on the wire.

During reads each received byte appears on a data output with a one-cycle valid strobe. The master acknowledges every byte except the one for which the host requested a not-acknowledge. That byte is answered with a NAK and followed by a STOP. A slave that refuses an address byte, or a written data byte, sets a sticky not-acknowledge flag and empties the holding register. The bus is then parked with SCL held Low until the host asks for a STOP. Both bus lines are open-drain: each output enable pulls its line Low when set.

Top module: `i2c_addr10_master`

## Requirements
- R1: After reset, and whenever busy is 0, sclOe and sdaOe are both 0 (both lines released) and nakFlag is 0 until the first refused byte.
- R2: SCL is high for exactly 2*QUARTER_CYCLES clocks in every pulse. SDA changes while SCL is high only as START (SDA falls) or STOP (SDA rises), and only while busy.
- R3: With mode10=0 a single address byte is sent MSB first: slaveAddr[6:0] followed by the direction bit (1 = read, readDir).
- R4: With mode10=1 the first address byte is 11110, slaveAddr[9:8], 0. The second byte, slaveAddr[7:0], is sent only if the first was acknowledged.
- R5: A 10-bit read sends both address bytes, then a repeated START, then 11110, slaveAddr[9:8], 1, and then receives data.
- R6: A byte counts as acknowledged when SDA is Low at the SCL rise of its ninth clock. Otherwise it counts as refused.
- R7: A refused address or write-data byte sets nakFlag, empties the transmit holding register and keeps SCL Low. Nothing else happens until cmdStop, and then a STOP is issued. nakFlag clears at the next accepted cmdStart.
- R8: Write data is sent MSB first from the holding register, which is loaded by txWrite. txIrq pulses for one cycle after the first bit of each data byte has shifted out.
- R9: If the holding register is empty after a data byte, SCL is held Low until txWrite or cmdStop. When txWrite and cmdStop arrive in the same cycle, the byte is sent before the STOP.
- R10: Each received byte is shown on rxData with a one-cycle rxValid. The master drives ACK (SDA Low) on every read byte, unless cmdNak was given before that byte's eighth bit ended. In that case it sends NAK and then a STOP.
- R11: busy rises when cmdStart is accepted in the idle state and falls after the STOP completes. A cmdStart while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active Low |
| cmdStart | input | 1 | Begin a transfer (pulse) |
| cmdStop | input | 1 | Request STOP (pulse) |
| cmdNak | input | 1 | Answer the next received byte with NAK, then STOP (pulse) |
| mode10 | input | 1 | 1 selects 10-bit addressing |
| readDir | input | 1 | 1 selects a read transfer |
| slaveAddr | input | 10 | Slave address; bits 6:0 used in 7-bit mode |
| txData | input | 8 | Byte for the transmit holding register |
| txWrite | input | 1 | Load txData into the holding register |
| txIrq | output | 1 | Transmit interrupt pulse |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | rxData strobe |
| nakFlag | output | 1 | Sticky not-acknowledge flag |
| busy | output | 1 | Transfer in progress |
| sclOe | output | 1 | 1 pulls SCL Low |
| sdaOe | output | 1 | 1 pulls SDA Low |
| sdaIn | input | 1 | Sampled SDA line |

## Verification
A data-byte load and a STOP request can land in the same cycle while the bus is parked between write bytes. The bench provokes this by raising txWrite and cmdStop together after the address phase. The bus log must then show the byte, with its acknowledge, ahead of the STOP. Similar collisions are covered too: a NAK request made while a read byte is already shifting, and a cmdStart raised in the middle of a transfer. These are judged by comparing every START, STOP and 9-bit byte seen by a bus monitor against a sequence the bench builds from the address and data it chose.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_BYTE} opKind_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic       goStart;
    logic       goStop;
    logic       goByte;
    logic       rdByte;
    logic [7:0] txByte;
  } dpCmd_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR1, ST_ADDR2, ST_RSTART, ST_ADDR3,
    ST_WAITTX, ST_TX, ST_RX, ST_NAKWAIT, ST_STOP
  } ctrlState_t;
endpackage

// File: rtl/i2cm_dp.sv
module i2cm_dp import i2cm_pkg::*; #(
  parameter int QUARTER_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic       ackLowIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       opDone,
  output logic       firstBitDone,
  output logic       ackBit,
  output logic [7:0] rxByte
);
  localparam int CW = (QUARTER_CYCLES > 1) ? $clog2(QUARTER_CYCLES) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(QUARTER_CYCLES - 1);

  logic          active, rdMode, ackLatch, sclHold, sdaHold;
  opKind_t       kind;
  logic [1:0]    quarter;
  logic [3:0]    bitIdx;
  logic [CW-1:0] divCnt;
  logic [7:0]    txSh, rxSh;
  logic          tick, sclLow, sdaLow;

  assign tick   = active && (divCnt == DIV_LAST);
  assign rxByte = rxSh;
  assign sclOe  = sclLow;
  assign sdaOe  = sdaLow;

  // bit cell: q0 SCL low (SDA set), q1/q2 SCL high, q3 SCL low
  always_comb begin
    sclLow = sclHold;
    sdaLow = sdaHold;
    if (active) begin
      unique case (kind)
        OP_START: begin
          sclLow = (quarter == 2'd0) || (quarter == 2'd3);
          sdaLow = quarter[1];
        end
        OP_STOP: begin
          sclLow = (quarter == 2'd0);
          sdaLow = !quarter[1];
        end
        default: begin
          sclLow = (quarter == 2'd0) || (quarter == 2'd3);
          sdaLow = (bitIdx == 4'd8) ? (rdMode && ackLatch) : (!rdMode && !txSh[7]);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0; rdMode <= 1'b0; ackLatch <= 1'b0; ackBit <= 1'b1;
      sclHold <= 1'b0; sdaHold <= 1'b0; kind <= OP_START;
      quarter <= '0; bitIdx <= '0; divCnt <= '0; txSh <= '0; rxSh <= '0;
      opDone <= 1'b0; firstBitDone <= 1'b0;
    end else begin
      opDone <= 1'b0;
      firstBitDone <= 1'b0;
      if (!active) begin
        if (cmd.goStart || cmd.goStop || cmd.goByte) begin
          active  <= 1'b1;
          kind    <= cmd.goStart ? OP_START : (cmd.goStop ? OP_STOP : OP_BYTE);
          rdMode  <= cmd.rdByte;
          txSh    <= cmd.txByte;
          quarter <= '0;
          divCnt  <= '0;
          bitIdx  <= '0;
        end
      end else if (tick) begin
        divCnt  <= '0;
        quarter <= quarter + 2'd1;
        if (quarter == 2'd0 && kind == OP_BYTE) begin
          if (bitIdx == 4'd8) ackBit <= sdaIn;
          else                rxSh   <= {rxSh[6:0], sdaIn};
        end
        if (quarter == 2'd3) begin
          if (kind == OP_BYTE && bitIdx != 4'd8) begin
            bitIdx <= bitIdx + 4'd1;
            txSh   <= {txSh[6:0], 1'b1};
            if (bitIdx == 4'd7) ackLatch <= ackLowIn;
            if (bitIdx == 4'd0) firstBitDone <= 1'b1;
          end else begin
            active  <= 1'b0;
            opDone  <= 1'b1;
            sclHold <= sclLow;
            sdaHold <= sdaLow;
          end
        end
      end else begin
        divCnt <= divCnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl import i2cm_pkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       cmdStop,
  input  logic       cmdNak,
  input  logic       mode10,
  input  logic       readDir,
  input  logic [9:0] slaveAddr,
  input  logic [7:0] txData,
  input  logic       txWrite,
  input  logic       opDone,
  input  logic       firstBitDone,
  input  logic       ackBit,
  input  logic [7:0] rxByte,
  output dpCmd_t     cmd,
  output logic       ackLowOut,
  output logic       busy,
  output logic       nakFlag,
  output logic       txIrq,
  output logic [7:0] rxData,
  output logic       rxValid
);
  ctrlState_t state;
  logic [9:0] addrR;
  logic       rdR, m10R, txFull, stopPend, nakReq;
  logic [7:0] txHold;

  function automatic dpCmd_t sendByte(input logic [7:0] b);
    dpCmd_t c = '0;
    c.goByte = 1'b1;
    c.txByte = b;
    return c;
  endfunction

  function automatic dpCmd_t recvByte();
    dpCmd_t c = '0;
    c.goByte = 1'b1;
    c.rdByte = 1'b1;
    c.txByte = 8'hFF;
    return c;
  endfunction

  assign busy      = (state != ST_IDLE);
  assign ackLowOut = !nakReq;
  assign txIrq     = firstBitDone && (state == ST_TX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; addrR <= '0; rdR <= 1'b0; m10R <= 1'b0;
      txFull <= 1'b0; txHold <= '0; stopPend <= 1'b0; nakReq <= 1'b0;
      nakFlag <= 1'b0; cmd <= '0; rxData <= '0; rxValid <= 1'b0;
    end else begin
      cmd     <= '0;
      rxValid <= 1'b0;
      if (cmdStop && state != ST_IDLE) stopPend <= 1'b1;
      if (cmdNak) nakReq <= 1'b1;
      unique case (state)
        ST_IDLE: if (cmdStart) begin
          addrR <= slaveAddr; rdR <= readDir; m10R <= mode10;
          nakFlag <= 1'b0; stopPend <= 1'b0;
          cmd.goStart <= 1'b1;
          state <= ST_START;
        end
        ST_START: if (opDone) begin
          cmd   <= sendByte(m10R ? {TEN_BIT_PREFIX, addrR[9:8], 1'b0} : {addrR[6:0], rdR});
          state <= ST_ADDR1;
        end
        ST_ADDR1: if (opDone) begin
          if (ackBit) begin
            nakFlag <= 1'b1; txFull <= 1'b0; state <= ST_NAKWAIT;
          end else if (m10R) begin
            cmd <= sendByte(addrR[7:0]); state <= ST_ADDR2;
          end else if (rdR) begin
            cmd <= recvByte(); state <= ST_RX;
          end else state <= ST_WAITTX;
        end
        ST_ADDR2: if (opDone) begin
          if (ackBit) begin
            nakFlag <= 1'b1; txFull <= 1'b0; state <= ST_NAKWAIT;
          end else if (rdR) begin
            cmd.goStart <= 1'b1; state <= ST_RSTART;
          end else state <= ST_WAITTX;
        end
        ST_RSTART: if (opDone) begin
          cmd   <= sendByte({TEN_BIT_PREFIX, addrR[9:8], 1'b1});
          state <= ST_ADDR3;
        end
        ST_ADDR3: if (opDone) begin
          if (ackBit) begin
            nakFlag <= 1'b1; txFull <= 1'b0; state <= ST_NAKWAIT;
          end else begin
            cmd <= recvByte(); state <= ST_RX;
          end
        end
        ST_WAITTX: begin
          if (txFull) begin
            cmd <= sendByte(txHold); txFull <= 1'b0; state <= ST_TX;
          end else if (stopPend) begin
            cmd.goStop <= 1'b1; stopPend <= 1'b0; state <= ST_STOP;
          end
        end
        ST_TX: if (opDone) begin
          if (ackBit) begin
            nakFlag <= 1'b1; txFull <= 1'b0; state <= ST_NAKWAIT;
          end else state <= ST_WAITTX;
        end
        ST_RX: if (opDone) begin
          rxValid <= 1'b1;
          rxData  <= rxByte;
          if (ackBit) begin  // SDA was released in the ack slot: NAK sent
            nakReq <= 1'b0; cmd.goStop <= 1'b1; stopPend <= 1'b0; state <= ST_STOP;
          end else cmd <= recvByte();
        end
        ST_NAKWAIT: if (stopPend) begin
          cmd.goStop <= 1'b1; stopPend <= 1'b0; state <= ST_STOP;
        end
        ST_STOP: if (opDone) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (txWrite) begin
        txHold <= txData;
        txFull <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_addr10_master.sv
module i2c_addr10_master import i2cm_pkg::*; #(
  parameter int QUARTER_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic       cmdStop,
  input  logic       cmdNak,
  input  logic       mode10,
  input  logic       readDir,
  input  logic [9:0] slaveAddr,
  input  logic [7:0] txData,
  input  logic       txWrite,
  output logic       txIrq,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       nakFlag,
  output logic       busy,
  output logic       sclOe,
  output logic       sdaOe,
  input  logic       sdaIn
);
  dpCmd_t     dpCmd;
  logic       opDone, firstBitDone, ackBit, ackLow;
  logic [7:0] rxByte;

  i2cm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdStop(cmdStop), .cmdNak(cmdNak),
    .mode10(mode10), .readDir(readDir), .slaveAddr(slaveAddr), .txData(txData),
    .txWrite(txWrite), .opDone(opDone), .firstBitDone(firstBitDone), .ackBit(ackBit),
    .rxByte(rxByte), .cmd(dpCmd), .ackLowOut(ackLow), .busy(busy), .nakFlag(nakFlag),
    .txIrq(txIrq), .rxData(rxData), .rxValid(rxValid)
  );

  i2cm_dp #(.QUARTER_CYCLES(QUARTER_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(dpCmd), .ackLowIn(ackLow), .sdaIn(sdaIn),
    .sclOe(sclOe), .sdaOe(sdaOe), .opDone(opDone), .firstBitDone(firstBitDone),
    .ackBit(ackBit), .rxByte(rxByte)
  );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic sclOe,
  input logic sdaOe,
  input logic txIrq,
  input logic rxValid,
  input logic nakFlag
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclOe && !sdaOe));

  assert_start_only_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!sclOe && $past(!sclOe) && $rose(sdaOe)) |-> busy);

  assert_stop_only_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!sclOe && $past(!sclOe) && $fell(sdaOe)) |-> $past(busy));

  assert_nak_in_txn_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nakFlag) |-> busy);

  assert_txirq_scl_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> (busy && sclOe));

  assert_rxvalid_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
endmodule

bind i2c_addr10_master i2cm_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .sclOe(sclOe), .sdaOe(sdaOe),
  .txIrq(txIrq), .rxValid(rxValid), .nakFlag(nakFlag)
);

// File: tb/i2c_addr10_master_bench.sv
module i2c_addr10_master_bench;
  localparam int Q = 4;
  localparam logic [6:0] A7 = 7'h52;
  localparam logic [9:0] A10 = 10'h2B6;
  localparam logic [7:0] RD_BASE = 8'hA5;
  localparam int EV_START = 1000, EV_STOP = 2000;

  logic clk = 0, rstN = 0;
  logic cmdStart = 0, cmdStop = 0, cmdNak = 0, mode10 = 0, readDir = 0, txWrite = 0;
  logic [9:0] slaveAddr = '0;
  logic [7:0] txData = '0;
  logic txIrq, rxValid, nakFlag, busy, sclOe, sdaOe;
  logic [7:0] rxData;
  logic slvLow = 0;
  wire sclBus = !sclOe;
  wire sdaBus = !(sdaOe || slvLow);

  always #4 clk = !clk;

  i2c_addr10_master #(.QUARTER_CYCLES(Q)) u_i2c_addr10_master (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdStop(cmdStop), .cmdNak(cmdNak),
    .mode10(mode10), .readDir(readDir), .slaveAddr(slaveAddr), .txData(txData),
    .txWrite(txWrite), .txIrq(txIrq), .rxData(rxData), .rxValid(rxValid),
    .nakFlag(nakFlag), .busy(busy), .sclOe(sclOe), .sdaOe(sdaOe), .sdaIn(sdaBus)
  );

  int nChecks = 0, nFail = 0;
  int logv[64]; int logN = 0;
  int expv[64]; int expN = 0;
  int rxv[16];  int rxN = 0;
  int irqN = 0, sclErr = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- bus monitor and slave model ----------------
  localparam int P_ADDR = 0, P_A10LO = 1, P_WDATA = 2, P_RDSTART = 3, P_READ = 4, P_IGN = 5;
  int phase = P_IGN, bitCnt = 0, hiCnt = 0;
  bit pS = 1, pD = 1, sel10 = 0, ackSeen = 0, hiValid = 0;
  logic [7:0] shIn = 0, txv = 0;

  always @(negedge clk) begin
    bit s, d;
    cyc++;
    if (rxValid) begin rxv[rxN] = int'(rxData); rxN++; end
    if (txIrq) irqN++;
    s = sclBus; d = sdaBus;
    if (s) hiCnt = pS ? hiCnt + 1 : 1;
    if (!rstN) begin
      phase = P_IGN; bitCnt = 0; slvLow = 0;
    end else if (s && pS && pD && !d) begin
      logv[logN] = EV_START; logN++;
      phase = P_ADDR; bitCnt = 0; slvLow = 0;
    end else if (s && pS && !pD && d) begin
      logv[logN] = EV_STOP; logN++;
      phase = P_IGN; sel10 = 0; bitCnt = 0; slvLow = 0; hiValid = 0;
    end else if (s && !pS) begin
      hiValid = 1;
      if (bitCnt < 8) shIn = {shIn[6:0], d}; else ackSeen = d;
      bitCnt++;
    end else if (!s && pS) begin
      if (hiValid && hiCnt != 2 * Q) sclErr++;
      if (bitCnt == 8) begin
        slvLow = 0;
        case (phase)
          P_ADDR: begin
            if (shIn[7:3] == 5'b11110) begin
              if (shIn[2:1] == A10[9:8] && !shIn[0]) begin slvLow = 1; phase = P_A10LO; end
              else if (shIn[2:1] == A10[9:8] && shIn[0] && sel10) begin slvLow = 1; phase = P_RDSTART; end
              else phase = P_IGN;
            end else if (shIn[7:1] == A7) begin
              slvLow = 1; phase = shIn[0] ? P_RDSTART : P_WDATA;
            end else phase = P_IGN;
          end
          P_A10LO: if (shIn == A10[7:0]) begin slvLow = 1; sel10 = 1; phase = P_WDATA; end
                   else phase = P_IGN;
          P_WDATA: slvLow = 1;
          default: slvLow = 0;
        endcase
      end else if (bitCnt == 9) begin
        logv[logN] = {23'd0, ackSeen, shIn}; logN++;
        bitCnt = 0; slvLow = 0;
        if (phase == P_RDSTART && !ackSeen) begin
          phase = P_READ; txv = RD_BASE; slvLow = !txv[7];
        end else if (phase == P_READ) begin
          if (!ackSeen) begin txv = txv + 8'd1; slvLow = !txv[7]; end
          else phase = P_IGN;
        end
      end else if (phase == P_READ && bitCnt >= 1 && bitCnt <= 7) begin
        slvLow = !txv[7 - bitCnt];
      end
    end
    pS = s; pD = d;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) if (cyc > 150000) begin
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  // ---------------- helpers ----------------
  task automatic clearLog(); logN = 0; expN = 0; rxN = 0; irqN = 0; endtask
  task automatic ex(input int v); expv[expN] = v; expN++; endtask
  function automatic int ack(input logic [7:0] b); return int'(b); endfunction
  function automatic int nak(input logic [7:0] b); return 256 + int'(b); endfunction

  task automatic checkLog(input string req);
    chk(logN == expN, {req, " event count"}, logN, expN);
    for (int i = 0; i < expN && i < logN; i++)
      chk(logv[i] == expv[i], {req, " bus event"}, logv[i], expv[i]);
  endtask

  task automatic startTxn(input bit m10, input bit rd, input logic [9:0] a);
    @(negedge clk); mode10 = m10; readDir = rd; slaveAddr = a; cmdStart = 1;
    @(negedge clk); cmdStart = 0;
  endtask
  task automatic writeByte(input logic [7:0] d);
    @(negedge clk); txData = d; txWrite = 1;
    @(negedge clk); txWrite = 0;
  endtask
  task automatic pulseStop();
    @(negedge clk); cmdStop = 1; @(negedge clk); cmdStop = 0;
  endtask
  task automatic pulseNak();
    @(negedge clk); cmdNak = 1; @(negedge clk); cmdNak = 0;
  endtask
  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask
  task automatic waitIrq();
    @(negedge clk);
    while (!txIrq) @(negedge clk);
  endtask

  task automatic doWrite(input bit m10, input logic [9:0] a, input int n, input logic [7:0] base, input string req);
    clearLog();
    ex(EV_START);
    if (m10) begin ex(ack({5'b11110, a[9:8], 1'b0})); ex(ack(a[7:0])); end
    else ex(ack({a[6:0], 1'b0}));
    for (int i = 0; i < n; i++) ex(ack(base + 8'(i * 37)));
    ex(EV_STOP);
    writeByte(base);
    startTxn(m10, 0, a);
    chk(busy == 1, "R11 busy after start", busy, 1);
    for (int i = 1; i < n; i++) begin
      waitIrq();
      writeByte(base + 8'(i * 37));
    end
    waitIrq();
    pulseStop();
    waitIdle();
    checkLog(req);
    chk(irqN == n, "R8 txIrq count", irqN, n);
    chk(busy == 0 && !sclOe && !sdaOe, "R1 released after STOP", {busy, sclOe, sdaOe}, 0);
  endtask

  task automatic doAddrNak(input bit m10, input logic [9:0] a, input bit loSent, input string req);
    clearLog();
    ex(EV_START);
    if (m10) begin
      if (loSent) begin ex(ack({5'b11110, a[9:8], 1'b0})); ex(nak(a[7:0])); end
      else ex(nak({5'b11110, a[9:8], 1'b0}));
    end else ex(nak({a[6:0], 1'b0}));
    ex(EV_STOP);
    writeByte(8'h77);
    startTxn(m10, 0, a);
    while (!nakFlag && busy) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(nakFlag == 1, "R7 nakFlag set", nakFlag, 1);
    chk(busy == 1 && sclOe == 1, "R7 SCL parked Low until stop", {busy, sclOe}, 3);
    pulseStop();
    waitIdle();
    checkLog(req);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(busy == 0, "R1 reset busy", busy, 0);
    chk(sclOe == 0 && sdaOe == 0, "R1 reset lines released", {sclOe, sdaOe}, 0);
    chk(nakFlag == 0, "R1 reset nakFlag", nakFlag, 0);
    rstN = 1;
    repeat (5) @(negedge clk);

    // R3 / R8: 7-bit writes of 1..3 bytes
    for (int k = 0; k < 3; k++) doWrite(0, {3'b000, A7}, k + 1, 8'h11 + 8'(k * 50), "R3 R8 7-bit write");

    // R4: 10-bit writes
    doWrite(1, A10, 2, 8'hC3, "R4 10-bit write");
    doWrite(1, A10, 1, 8'h00, "R4 10-bit write zero data");

    // R6 / R7: refused addresses (sweep of single-bit mismatches)
    for (int j = 0; j < 4; j++) doAddrNak(0, {3'b000, A7 ^ 7'(1 << j)}, 0, "R6 R7 7-bit address NAK");
    doAddrNak(1, A10 ^ 10'h001, 1, "R4 R7 10-bit low byte NAK");
    doAddrNak(1, A10 ^ 10'h100, 0, "R4 R7 10-bit high byte NAK, low byte not sent");

    // R7: holding register flushed, nakFlag cleared on next start
    clearLog();
    ex(EV_START); ex(ack({A7, 1'b0})); ex(EV_STOP);
    startTxn(0, 0, {3'b000, A7});
    chk(nakFlag == 0, "R7 nakFlag cleared by start", nakFlag, 1'b0);
    repeat (400) @(negedge clk);
    chk(sclOe == 1 && busy == 1, "R9 SCL held Low with empty holding", {sclOe, busy}, 3);
    pulseStop();
    waitIdle();
    checkLog("R7 flushed holding register sends nothing");

    // R5 / R10: 10-bit read of 3 bytes, NAK requested while third byte shifts
    clearLog();
    ex(EV_START); ex(ack({5'b11110, A10[9:8], 1'b0})); ex(ack(A10[7:0]));
    ex(EV_START); ex(ack({5'b11110, A10[9:8], 1'b1}));
    ex(ack(RD_BASE)); ex(ack(RD_BASE + 8'd1)); ex(nak(RD_BASE + 8'd2)); ex(EV_STOP);
    startTxn(1, 1, A10);
    while (rxN < 2) @(negedge clk);
    pulseNak();
    waitIdle();
    checkLog("R5 R10 10-bit read");
    chk(rxN == 3, "R10 read byte count", rxN, 3);
    for (int i = 0; i < 3 && i < rxN; i++)
      chk(rxv[i] == int'(RD_BASE) + i, "R10 rxData", rxv[i], int'(RD_BASE) + i);

    // R10: single-byte 7-bit read, NAK requested before start
    clearLog();
    ex(EV_START); ex(ack({A7, 1'b1})); ex(nak(RD_BASE)); ex(EV_STOP);
    pulseNak();
    startTxn(0, 1, {3'b000, A7});
    waitIdle();
    checkLog("R3 R10 single-byte read");
    chk(rxN == 1 && rxv[0] == int'(RD_BASE), "R10 single rxData", rxv[0], RD_BASE);

    // R9 / R11: txWrite and cmdStop in the same cycle; cmdStart while busy ignored
    clearLog();
    ex(EV_START); ex(ack({A7, 1'b0})); ex(ack(8'h3C)); ex(EV_STOP);
    startTxn(0, 0, {3'b000, A7});
    repeat (100) @(negedge clk);
    startTxn(1, 1, A10);
    chk(busy == 1, "R11 busy kept during ignored start", busy, 1);
    repeat (300) @(negedge clk);
    @(negedge clk); txData = 8'h3C; txWrite = 1; cmdStop = 1;
    @(negedge clk); txWrite = 0; cmdStop = 0;
    waitIdle();
    checkLog("R9 R11 write and stop same cycle");
    chk(irqN == 1, "R8 txIrq on late byte", irqN, 1);

    chk(sclErr == 0, "R2 SCL high time", sclErr, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule